// File: doc/BRIEF.md
# Timebase Synchronization Sequencer

This block is the per-core controller that walks a core's timebase through the steps needed to line it up with a chip-wide time-of-day source. Software issues commands by writing a small command field (load-mode, move-to-timebase, clear-errors and an error-acknowledge bit). The hardware side supplies a sync pulse, a strobe telling the core that the time-of-day value has been transferred, and event strobes for writes to the upper and lower halves of the timebase. The block answers with a 64-bit status word carrying the current and previous state codes plus a handful of flags, and with a ready-for-TOD output that tells the time-of-day source it may send.

The sequence is reset, send-mode, not-set, sync-wait, get-TOD, running. Commands given in the wrong state, two conflicting commands, or a lower-half timebase write while running send the machine into a sticky error state. Only the clear-errors command leaves that state. The block models sequencing and error handling only: it does not count time.

Top module: `tbsync_ctrl`

## Requirements
- R1: Synchronous active-high reset gives state code 0 and a status word of all zeros. Status word layout: bit 0 load-mode pending, bit 1 move-to-timebase pending, bit 3 firmware-control-error, bit 4 sync-occurred, bit 5 timebase-valid, bit 6 ready-for-TOD, bits [31:28] current state, bits [27:24] last state, all other bits 0. State codes: 0 reset, 1 send-mode, 2 not-set, 6 sync-wait, 7 get-TOD, 8 running, 9 error. Codes 3, 4 and 5 never appear.
- R2: The command field is wr_cmd_i bit 0 load-mode, bit 1 move, bit 2 clear-errors, bit 3 error-acknowledge. A load-mode write in any state except get-TOD and error moves to send-mode (1) with status bit 0 set. The next clock moves it to not-set (2) and clears bit 0.
- R3: A move write in not-set enters sync-wait (6) and raises ready-for-TOD. A sync pulse in sync-wait then enters get-TOD (7).
- R4: In get-TOD, a transfer strobe, or one already latched while ready-for-TOD was high, enters running (8). This clears the move bit, ready-for-TOD and the latched transfer.
- R5: In running, an upper-half timebase write leaves the state unchanged. A lower-half write enters error (9).
- R6: A write with load-mode and move both set enters error and sets firmware-control-error, from any state.
- R7: A move write outside not-set, or a load-mode write in get-TOD, enters error and sets firmware-control-error.
- R8: A clear-errors write, unless load-mode and move are both set, enters reset (0) and clears load-mode, move, firmware-control-error and ready-for-TOD.
- R9: Whenever the state changes, the old code is copied into the last-state field. Timebase-valid is 1 exactly while the state is running.
- R10: A write with the error-acknowledge bit clears firmware-control-error unless the same write sets it. Sync-occurred reads 0 after every write and returns to 1 on the SYNC_DLY+1-th clock after the last write.
- R11: In error, a write carrying load-mode or move but not clear-errors keeps the state and sets firmware-control-error. Events are ignored there.
- R12: At most one transition per clock. A write outranks the sync, transfer and timebase-write events in the same clock, and those events are then dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_cmd_i | input | 4 | Command field of the write |
| sync_pulse_i | input | 1 | Sync pulse from the time-of-day source |
| tod_xfer_i | input | 1 | Time-of-day transferred strobe |
| tbu_wr_i | input | 1 | Upper-half timebase write event |
| tbl_wr_i | input | 1 | Lower-half timebase write event |
| stat_o | output | 64 | Status word |
| tod_ready_o | output | 1 | Ready-for-TOD indication |
| tb_valid_o | output | 1 | Timebase-valid flag |

## Verification
Every state, bit and flag change shows on the status word one clock after the edge that sampled the write or event. The one exception is send-mode, which moves on to not-set one clock after that. Sync-occurred lags the last write by SYNC_DLY+1 clocks. The bench drives inputs just after a rising edge and samples one edge later. Each cycle it compares the whole status word against a model built from the requirements. Tagged directed checks are placed on the exact clock where each result is due, including the three clocks of the sync-occurred countdown.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    localparam int STAT_W   = 64;
    localparam int CMD_W    = 4;
    localparam int CODE_W   = 4;
    localparam int CUR_LSB  = 28;
    localparam int LAST_LSB = CUR_LSB - CODE_W;

    localparam int B_LOAD  = 0;
    localparam int B_MOVE  = 1;
    localparam int B_CLR   = 2;
    localparam int B_FWERR = 3;
    localparam int B_SYNC  = 4;
    localparam int B_VALID = 5;
    localparam int B_READY = 6;

    typedef enum logic [CODE_W-1:0] {
        ST_RESET  = 4'd0,
        ST_SEND   = 4'd1,
        ST_NOTSET = 4'd2,
        ST_SYNCW  = 4'd6,
        ST_GETTOD = 4'd7,
        ST_RUN    = 4'd8,
        ST_ERR    = 4'd9
    } tb_state_e;

    typedef struct packed {
        logic load;
        logic move;
        logic clr;
        logic ack;
    } wr_cmd_t;

    typedef struct packed {
        logic ld;
        logic mv;
        logic fw;
        logic rdy;
        logic xf;
    } ctl_flags_t;

    function automatic logic code_is_legal(input logic [CODE_W-1:0] c);
        return (c == ST_RESET) || (c == ST_SEND) || (c == ST_NOTSET) ||
               (c == ST_SYNCW) || (c == ST_GETTOD) || (c == ST_RUN) ||
               (c == ST_ERR);
    endfunction

endpackage

// File: rtl/tbs_cmd_decode.sv
module tbs_cmd_decode
    import tbs_pkg::*;
(
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_cmd,
    output wr_cmd_t          cmd
);
    always_comb begin
        cmd.load = wr_en & wr_cmd[B_LOAD];
        cmd.move = wr_en & wr_cmd[B_MOVE];
        cmd.clr  = wr_en & wr_cmd[B_CLR];
        cmd.ack  = wr_en & wr_cmd[B_FWERR];
    end
endmodule

// File: rtl/tbs_sync_flag.sv
module tbs_sync_flag #(
    parameter int SYNC_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    output logic sync_o
);
    localparam int CW = (SYNC_DLY < 1) ? 1 : $clog2(SYNC_DLY + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SYNC_DLY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= RELOAD;
            sync_o <= 1'b0;
        end else if (wr_en) begin
            cnt_q  <= RELOAD;
            sync_o <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            sync_o <= 1'b1;
        end
    end

    p_sync_clr_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !sync_o);

    p_sync_set_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && cnt_q == '0) |=> sync_o);
endmodule

// File: rtl/tbs_fsm.sv
module tbs_fsm
    import tbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  wr_cmd_t   cmd,
    input  logic      sync_pulse,
    input  logic      tod_xfer,
    input  logic      tbu_wr,
    input  logic      tbl_wr,
    output tb_state_e cur_q,
    output tb_state_e last_q,
    output ctl_flags_t flg_q,
    output logic      valid_q
);
    tb_state_e  nxt;
    ctl_flags_t fn;

    always_comb begin
        nxt = cur_q;
        fn  = flg_q;
        if (flg_q.rdy && tod_xfer) fn.xf = 1'b1;
        if (wr_en) begin
            if (cmd.ack) fn.fw = 1'b0;
            if (cmd.load && cmd.move) begin
                nxt    = ST_ERR;
                fn.ld  = 1'b1;
                fn.mv  = 1'b1;
                fn.fw  = 1'b1;
                fn.rdy = 1'b0;
                fn.xf  = 1'b0;
            end else if (cmd.clr) begin
                nxt = ST_RESET;
                fn  = '0;
            end else if (cur_q == ST_ERR) begin
                if (cmd.load || cmd.move) fn.fw = 1'b1;
            end else if (cmd.load) begin
                fn.ld  = 1'b1;
                fn.mv  = 1'b0;
                fn.rdy = 1'b0;
                fn.xf  = 1'b0;
                if (cur_q == ST_GETTOD) begin
                    nxt   = ST_ERR;
                    fn.fw = 1'b1;
                end else begin
                    nxt = ST_SEND;
                end
            end else if (cmd.move) begin
                fn.mv = 1'b1;
                fn.ld = 1'b0;
                if (cur_q == ST_NOTSET) begin
                    nxt    = ST_SYNCW;
                    fn.rdy = 1'b1;
                end else begin
                    nxt    = ST_ERR;
                    fn.fw  = 1'b1;
                    fn.rdy = 1'b0;
                    fn.xf  = 1'b0;
                end
            end
        end else begin
            unique case (cur_q)
                ST_SEND: begin
                    nxt   = ST_NOTSET;
                    fn.ld = 1'b0;
                end
                ST_SYNCW: begin
                    if (sync_pulse) nxt = ST_GETTOD;
                end
                ST_GETTOD: begin
                    if (flg_q.xf || tod_xfer) begin
                        nxt    = ST_RUN;
                        fn.mv  = 1'b0;
                        fn.rdy = 1'b0;
                        fn.xf  = 1'b0;
                    end
                end
                ST_RUN: begin
                    if (tbl_wr) nxt = ST_ERR;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= ST_RESET;
            last_q  <= ST_RESET;
            flg_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (nxt != cur_q) last_q <= cur_q;
            cur_q   <= nxt;
            flg_q   <= fn;
            valid_q <= (nxt == ST_RUN);
        end
    end

    p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
        code_is_legal(cur_q));

    p_valid_run_r9: assert property (@(posedge clk) disable iff (rst)
        valid_q == (cur_q == ST_RUN));

    p_last_copy_r9: assert property (@(posedge clk) disable iff (rst)
        (nxt != cur_q) |=> (last_q == $past(cur_q)));

    p_both_err_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd.load && cmd.move) |=> (cur_q == ST_ERR && flg_q.fw));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd.clr && !(cmd.load && cmd.move)) |=>
        (cur_q == ST_RESET && !flg_q.ld && !flg_q.mv && !flg_q.fw && !flg_q.rdy));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_ERR && !(wr_en && cmd.clr)) |=> (cur_q == ST_ERR));

    p_send_auto_r2: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_SEND && !wr_en) |=> (cur_q == ST_NOTSET));
endmodule

// File: rtl/tbsync_ctrl.sv
module tbsync_ctrl
    import tbs_pkg::*;
#(
    parameter int SYNC_DLY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [CMD_W-1:0]  wr_cmd_i,
    input  logic              sync_pulse_i,
    input  logic              tod_xfer_i,
    input  logic              tbu_wr_i,
    input  logic              tbl_wr_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              tod_ready_o,
    output logic              tb_valid_o
);
    wr_cmd_t    cmd;
    tb_state_e  cur, last;
    ctl_flags_t flg;
    logic       valid, sync_seen;

    tbs_cmd_decode u_dec (
        .wr_en  (wr_en_i),
        .wr_cmd (wr_cmd_i),
        .cmd    (cmd)
    );

    tbs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en_i),
        .cmd        (cmd),
        .sync_pulse (sync_pulse_i),
        .tod_xfer   (tod_xfer_i),
        .tbu_wr     (tbu_wr_i),
        .tbl_wr     (tbl_wr_i),
        .cur_q      (cur),
        .last_q     (last),
        .flg_q      (flg),
        .valid_q    (valid)
    );

    tbs_sync_flag #(.SYNC_DLY(SYNC_DLY)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en_i),
        .sync_o (sync_seen)
    );

    always_comb begin
        stat_o = '0;
        stat_o[B_LOAD]  = flg.ld;
        stat_o[B_MOVE]  = flg.mv;
        stat_o[B_FWERR] = flg.fw;
        stat_o[B_SYNC]  = sync_seen;
        stat_o[B_VALID] = valid;
        stat_o[B_READY] = flg.rdy;
        stat_o[CUR_LSB +: CODE_W]  = cur;
        stat_o[LAST_LSB +: CODE_W] = last;
    end

    assign tod_ready_o = flg.rdy;
    assign tb_valid_o  = valid;

    p_ready_state_r3: assert property (@(posedge clk) disable iff (rst)
        tod_ready_o |-> (stat_o[CUR_LSB +: CODE_W] == ST_SYNCW ||
                         stat_o[CUR_LSB +: CODE_W] == ST_GETTOD));
endmodule

// File: tb/tbsync_ctrl_tb_top.sv
`timescale 1ns/100ps
module tbsync_ctrl_tb_top;
    localparam int DLY = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_cmd = '0;
    logic        sp = 1'b0, tx = 1'b0, tu = 1'b0, tl = 1'b0;
    logic [63:0] stat;
    logic        rdy, vld;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    int m_cur, m_last, m_cnt;
    bit m_ld, m_mv, m_fw, m_rdy, m_xf, m_sync;

    always #2.5 clk = ~clk;

    tbsync_ctrl #(.SYNC_DLY(DLY)) dut_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
        .sync_pulse_i(sp), .tod_xfer_i(tx), .tbu_wr_i(tu), .tbl_wr_i(tl),
        .stat_o(stat), .tod_ready_o(rdy), .tb_valid_o(vld)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic m_reset();
        m_cur = 0; m_last = 0; m_cnt = DLY;
        {m_ld, m_mv, m_fw, m_rdy, m_xf, m_sync} = '0;
    endtask

    function automatic logic [63:0] m_word();
        logic [63:0] w = '0;
        w[0] = m_ld; w[1] = m_mv; w[3] = m_fw; w[4] = m_sync;
        w[5] = (m_cur == 8); w[6] = m_rdy;
        w[31:28] = 4'(m_cur); w[27:24] = 4'(m_last);
        return w;
    endfunction

    task automatic m_step(input bit w, input logic [3:0] c, input bit p, x, u, l);
        int n = m_cur;
        if (m_rdy && x) m_xf = 1;
        if (w) begin
            if (c[3]) m_fw = 0;
            if (c[0] && c[1]) begin n = 9; m_ld = 1; m_mv = 1; m_fw = 1; m_rdy = 0; m_xf = 0; end
            else if (c[2]) begin n = 0; {m_ld, m_mv, m_fw, m_rdy, m_xf} = '0; end
            else if (m_cur == 9) begin if (c[0] || c[1]) m_fw = 1; end
            else if (c[0]) begin
                m_ld = 1; m_mv = 0; m_rdy = 0; m_xf = 0;
                if (m_cur == 7) begin n = 9; m_fw = 1; end else n = 1;
            end else if (c[1]) begin
                m_mv = 1; m_ld = 0;
                if (m_cur == 2) begin n = 6; m_rdy = 1; end
                else begin n = 9; m_fw = 1; m_rdy = 0; m_xf = 0; end
            end
            m_cnt = DLY; m_sync = 0;
        end else begin
            if (m_cur == 1) begin n = 2; m_ld = 0; end
            else if (m_cur == 6 && p) n = 7;
            else if (m_cur == 7 && (m_xf || x)) begin n = 8; m_mv = 0; m_rdy = 0; m_xf = 0; end
            else if (m_cur == 8 && l) n = 9;
            if (m_cnt != 0) m_cnt--; else m_sync = 1;
        end
        if (n != m_cur) m_last = m_cur;
        m_cur = n;
    endtask

    task automatic cyc(input bit w, input logic [3:0] c, input bit p, x, u, l);
        wr_en = w; wr_cmd = c; sp = p; tx = x; tu = u; tl = l;
        @(posedge clk);
        m_step(w, c, p, x, u, l);
        #1;
        wr_en = 0; wr_cmd = '0; sp = 0; tx = 0; tu = 0; tl = 0;
        chk("R12 model word", stat, m_word());
        chk("R3 ready pin", {63'd0, rdy}, {63'd0, m_rdy});
        chk("R9 valid pin", {63'd0, vld}, {63'd0, 1'b1 && (m_cur == 8)});
    endtask

    task automatic wr(input logic [3:0] c); cyc(1, c, 0, 0, 0, 0); endtask
    task automatic idle(); cyc(0, 4'd0, 0, 0, 0, 0); endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk("R1 reset word", stat, 64'd0);

        wr(4'b0001);
        chk("R2 send-mode", stat[31:28], 4'd1);
        chk("R2 load bit set", stat[0], 1'b1);
        idle();
        chk("R2 auto not-set", stat[31:28], 4'd2);
        chk("R9 last is send", stat[27:24], 4'd1);
        chk("R2 load bit cleared", stat[0], 1'b0);
        cyc(0, 4'd0, 0, 0, 0, 1);
        chk("R5 lower write in not-set", stat[31:28], 4'd2);
        wr(4'b0010);
        chk("R3 sync-wait", stat[31:28], 4'd6);
        chk("R3 ready raised", {63'd0, rdy}, 64'd1);
        chk("R10 sync cleared by write", stat[4], 1'b0);
        idle();
        chk("R10 sync low +1", stat[4], 1'b0);
        idle();
        chk("R10 sync low +2", stat[4], 1'b0);
        cyc(0, 4'd0, 0, 1, 0, 0);
        chk("R10 sync back +3", stat[4], 1'b1);
        chk("R4 latched xfer holds sync-wait", stat[31:28], 4'd6);
        cyc(1, 4'd0, 1, 0, 0, 0);
        chk("R12 pulse dropped during write", stat[31:28], 4'd6);
        cyc(0, 4'd0, 1, 0, 0, 0);
        chk("R3 get-TOD", stat[31:28], 4'd7);
        idle();
        chk("R4 running via latched xfer", stat[31:28], 4'd8);
        chk("R4 move bit cleared", stat[1], 1'b0);
        chk("R9 valid in running", stat[5], 1'b1);
        cyc(0, 4'd0, 0, 0, 1, 0);
        chk("R5 upper write keeps running", stat[31:28], 4'd8);
        cyc(0, 4'd0, 0, 0, 0, 1);
        chk("R5 lower write errors", stat[31:28], 4'd9);
        chk("R9 valid dropped", stat[5], 1'b0);
        wr(4'b0001);
        chk("R11 error sticky", stat[31:28], 4'd9);
        chk("R11 fw set", stat[3], 1'b1);
        wr(4'b1000);
        chk("R10 ack clears fw", stat[3], 1'b0);
        chk("R11 ack keeps error", stat[31:28], 4'd9);
        wr(4'b0100);
        chk("R8 clear to reset", stat[31:28], 4'd0);
        chk("R8 bits cleared", stat[3:0], 4'd0);
        wr(4'b0010);
        chk("R7 move outside not-set", stat[31:28], 4'd9);
        chk("R7 fw", stat[3], 1'b1);
        wr(4'b0100);
        wr(4'b0001); idle(); wr(4'b0010);
        cyc(0, 4'd0, 1, 0, 0, 0);
        chk("R3 get-TOD again", stat[31:28], 4'd7);
        wr(4'b0001);
        chk("R7 load in get-TOD", stat[31:28], 4'd9);
        wr(4'b0100);
        wr(4'b0011);
        chk("R6 both set errors", stat[31:28], 4'd9);
        chk("R6 fw and bits", stat[3:0], 4'b1011);
        wr(4'b0100);
        chk("R8 bits cleared after both", stat[3:0], 4'd0);
        wr(4'b0001); idle(); wr(4'b0010);
        cyc(0, 4'd0, 1, 0, 0, 0);
        cyc(0, 4'd0, 0, 1, 0, 0);
        chk("R4 running via strobe", stat[31:28], 4'd8);
        wr(4'b0001);
        chk("R2 load from running", stat[31:28], 4'd1);

        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            bit w = ($urandom % 100) < 35;
            logic [3:0] c;
            c[0] = ($urandom % 100) < 25;
            c[1] = ($urandom % 100) < 30;
            c[2] = ($urandom % 100) < 8;
            c[3] = ($urandom % 100) < 20;
            cyc(w, c, ($urandom % 100) < 30, ($urandom % 100) < 25,
                ($urandom % 100) < 15, ($urandom % 100) < 8);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule